// File: doc/BRIEF.md
# Debug Register Access Controller

This block holds the privileged debug register file of a processor core: four breakpoint address slots, a status word and a control word, reached through eight slot indices. The execution pipeline presents one move-to or move-from request per cycle. Each request carries a 3-bit slot index, a write flag, write data, the current privilege level and an alias-disable flag. One cycle later the block answers with a response valid flag, read data and an exception code. Hardware event inputs (breakpoint hits, single step, task-switch trap) set sticky status bits. A task-switch pulse wipes the per-task (local) breakpoint enables.

Every request is screened in a fixed order: privilege first, then the alias rule for slots 4 and 5, then the general-detect trap armed by control bit 13. Only the first failing check is reported, and a failing request changes no register, with one exception. A general-detect trap sets status bit 13 and disarms control bit 13 in the same cycle, so that the handler can then reach the registers. The response is driven by a small state machine whose state records the outcome of the previous cycle's request. The states are `ST_IDLE` (no request), `ST_DONE` (completed), `ST_GP_FAULT`, `ST_UD_FAULT` and `ST_DB_TRAP`. Every state moves, on each clock, to the state that matches the screening verdict for the request presented in that cycle, or to `ST_IDLE` when no request is presented.

Top module: `dbgrf_top`

## Requirements
- R1: A request with `req_valid`=1 gets `rsp_valid`=1 in the next cycle, and in no other cycle. Indices 0 to 3 read and write breakpoint address slots 0 to 3 (full 32 bits). Index 6 selects status and index 7 selects control.
- R2: With `alias_off`=0, index 4 behaves exactly as index 6 and index 5 behaves exactly as index 7.
- R3: With `alias_off`=1, any access to index 4 or 5 returns code 2 (invalid opcode) and changes no register.
- R4: Any access with `req_cpl` not equal to 0 returns code 1 (general protection) and changes no register.
- R5: Checks are applied in this order, and only the first failure is reported: privilege, then alias, then general detect.
- R6: While control bit 13 is 1, any otherwise legal access returns code 3 (debug) and does not complete. In the same cycle status bit 13 becomes 1 and control bit 13 becomes 0.
- R7: Status always reads with bits 10:4 and 31:16 at 1 and bit 12 at 0. Bit 11 reads as 1 and ignores writes. Only bits 3:0, 13, 14 and 15 are writable.
- R8: Control always reads with bit 10 at 1 and bits 12:11 and 15:14 at 0, whatever is written. All other bits are writable.
- R9: A `task_sw` pulse clears control bits 0, 2, 4 and 6 and leaves bits 1, 3, 5 and 7 unchanged.
- R10: `bp_hit[i]` sets status bit i, `step_hit` sets bit 14 and `trap_hit` sets bit 15. These bits stay set until software writes the status register.
- R11: After reset, the address slots read 0, status reads 0xFFFF0FF0 and control reads 0x00000400.
- R12: The exception code is 0 for none, 1 for GP, 2 for UD and 3 for debug. `rsp_rdata` is 0 for writes and for any request that raises an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_idx | input | 3 | Register slot index |
| req_wr | input | 1 | 1 = move to register, 0 = move from register |
| req_wdata | input | 32 | Write data |
| req_cpl | input | 2 | Current privilege level |
| alias_off | input | 1 | 1 = slots 4 and 5 fault instead of aliasing |
| task_sw | input | 1 | Task-switch pulse |
| bp_hit | input | 4 | Breakpoint condition detected, one per slot |
| step_hit | input | 1 | Single-step event |
| trap_hit | input | 1 | Task-switch trap event |
| rsp_valid | output | 1 | Response for previous cycle's request |
| rsp_exc | output | 2 | Exception code |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench combines several failures in one request: user privilege on an aliased index while the trap is armed, and an alias fault while the trap is armed. A design that scored the checks in the wrong order would return the wrong code, or would wrongly disarm the trap. The bench then confirms that the trap is still armed on the next access and that, once it fires, status bit 13 is set and control bit 13 is cleared. A design that did not disarm would lock out the handler. The bench also writes all-ones patterns into reserved fields and reads them back, fires a task switch with all enables set, and checks that hardware-set status bits survive idle cycles. A design that leaked reserved bits, cleared the global enables or let the sticky bits decay would fail these checks.

// File: rtl/dbgrf_pkg.sv
package dbgrf_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_GP   = 2'd1,
        EXC_UD   = 2'd2,
        EXC_DB   = 2'd3
    } exc_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DONE,
        ST_GP_FAULT,
        ST_UD_FAULT,
        ST_DB_TRAP
    } rsp_state_e;

    // status: storage mask and bits forced to one on read
    localparam logic [DW-1:0] STAT_RW_MASK  = 32'h0000_E00F;
    localparam logic [DW-1:0] STAT_FIXED_1  = 32'hFFFF_0FF0;
    // control: storage mask and bits forced to one on read
    localparam logic [DW-1:0] CTRL_RW_MASK  = 32'hFFFF_23FF;
    localparam logic [DW-1:0] CTRL_FIXED_1  = 32'h0000_0400;

    localparam int GD_BIT     = 13;
    localparam int STEP_BIT   = 14;
    localparam int TRAP_BIT   = 15;

    localparam logic [2:0] IDX_STAT = 3'd6;
    localparam logic [2:0] IDX_CTRL = 3'd7;

endpackage

// File: rtl/dbgrf_access_check.sv
module dbgrf_access_check
    import dbgrf_pkg::*;
(
    input  logic       req_valid,
    input  logic [2:0] req_idx,
    input  logic [1:0] req_cpl,
    input  logic       alias_off,
    input  logic       gd_armed,
    output exc_e       verdict,
    output logic       grant,
    output logic [2:0] eff_idx
);
    logic is_alias_slot;

    assign is_alias_slot = (req_idx[2:1] == 2'b10);

    always_comb begin
        eff_idx = is_alias_slot ? (req_idx | 3'b010) : req_idx;
        if (req_cpl != 2'd0) begin
            verdict = EXC_GP;
        end else if (is_alias_slot && alias_off) begin
            verdict = EXC_UD;
        end else if (gd_armed) begin
            verdict = EXC_DB;
        end else begin
            verdict = EXC_NONE;
        end
        grant = req_valid && (verdict == EXC_NONE);
    end

endmodule

// File: rtl/dbgrf_status_reg.sv
module dbgrf_status_reg
    import dbgrf_pkg::*;
#(
    parameter int NBP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [DW-1:0]  wdata,
    input  logic [NBP-1:0] bp_hit,
    input  logic           step_hit,
    input  logic           trap_hit,
    input  logic           gd_hit,
    output logic [DW-1:0]  rd_val
);
    logic [DW-1:0] st_q;
    logic [DW-1:0] st_d;
    logic [DW-1:0] hw_set;

    always_comb begin
        hw_set = '0;
        hw_set[NBP-1:0] = bp_hit;
        hw_set[STEP_BIT] = step_hit;
        hw_set[TRAP_BIT] = trap_hit;
        hw_set[GD_BIT]   = gd_hit;
    end

    always_comb begin
        st_d = wr_en ? (wdata & STAT_RW_MASK) : st_q;
        st_d = st_d | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d & STAT_RW_MASK;
        end
    end

    assign rd_val = (st_q & STAT_RW_MASK) | STAT_FIXED_1;

endmodule

// File: rtl/dbgrf_control_reg.sv
module dbgrf_control_reg
    import dbgrf_pkg::*;
#(
    parameter int NBP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          task_sw,
    input  logic          gd_clear,
    output logic [DW-1:0] rd_val,
    output logic          gd_armed
);
    logic [DW-1:0] ctl_q;
    logic [DW-1:0] ctl_d;
    logic [DW-1:0] local_mask;

    // local enables sit on even positions of the low 2*NBP bits
    always_comb begin
        local_mask = '0;
        for (int i = 0; i < NBP; i++) begin
            local_mask[2*i] = 1'b1;
        end
    end

    always_comb begin
        ctl_d = wr_en ? (wdata & CTRL_RW_MASK) : ctl_q;
        if (task_sw) begin
            ctl_d = ctl_d & ~local_mask;
        end
        if (gd_clear) begin
            ctl_d[GD_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d & CTRL_RW_MASK;
        end
    end

    assign rd_val   = (ctl_q & CTRL_RW_MASK) | CTRL_FIXED_1;
    assign gd_armed = ctl_q[GD_BIT];

endmodule

// File: rtl/dbgrf_top.sv
module dbgrf_top
    import dbgrf_pkg::*;
#(
    parameter int NBP = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [2:0]     req_idx,
    input  logic           req_wr,
    input  logic [31:0]    req_wdata,
    input  logic [1:0]     req_cpl,
    input  logic           alias_off,
    input  logic           task_sw,
    input  logic [NBP-1:0] bp_hit,
    input  logic           step_hit,
    input  logic           trap_hit,
    output logic           rsp_valid,
    output logic [1:0]     rsp_exc,
    output logic [31:0]    rsp_rdata
);
    localparam int IDXW = 3;

    exc_e          verdict;
    logic          grant;
    logic [2:0]    eff_idx;
    logic          gd_armed;
    logic          gd_fire;
    logic [DW-1:0] stat_rd;
    logic [DW-1:0] ctrl_rd;
    logic [DW-1:0] addr_q [NBP];
    logic [DW-1:0] rd_mux;
    logic [DW-1:0] rdata_q;
    rsp_state_e    state_q;
    rsp_state_e    state_d;

    dbgrf_access_check u_chk_acc (
        .req_valid (req_valid),
        .req_idx   (req_idx),
        .req_cpl   (req_cpl),
        .alias_off (alias_off),
        .gd_armed  (gd_armed),
        .verdict   (verdict),
        .grant     (grant),
        .eff_idx   (eff_idx)
    );

    assign gd_fire = req_valid && (verdict == EXC_DB);

    dbgrf_status_reg #(.NBP(NBP)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (grant && req_wr && (eff_idx == IDX_STAT)),
        .wdata    (req_wdata),
        .bp_hit   (bp_hit),
        .step_hit (step_hit),
        .trap_hit (trap_hit),
        .gd_hit   (gd_fire),
        .rd_val   (stat_rd)
    );

    dbgrf_control_reg #(.NBP(NBP)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (grant && req_wr && (eff_idx == IDX_CTRL)),
        .wdata    (req_wdata),
        .task_sw  (task_sw),
        .gd_clear (gd_fire),
        .rd_val   (ctrl_rd),
        .gd_armed (gd_armed)
    );

    for (genvar g = 0; g < NBP; g++) begin : g_addr
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q[g] <= '0;
            end else if (grant && req_wr && (eff_idx == IDXW'(g))) begin
                addr_q[g] <= req_wdata;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (eff_idx == IDX_STAT) begin
            rd_mux = stat_rd;
        end else if (eff_idx == IDX_CTRL) begin
            rd_mux = ctrl_rd;
        end else begin
            for (int i = 0; i < NBP; i++) begin
                if (eff_idx == IDXW'(i)) rd_mux = addr_q[i];
            end
        end
    end

    // next-state: outcome of the request presented this cycle
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            unique case (verdict)
                EXC_NONE: state_d = ST_DONE;
                EXC_GP:   state_d = ST_GP_FAULT;
                EXC_UD:   state_d = ST_UD_FAULT;
                EXC_DB:   state_d = ST_DB_TRAP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (grant && !req_wr) ? rd_mux : '0;
        end
    end

    // output process
    always_comb begin
        rsp_valid = 1'b1;
        rsp_exc   = EXC_NONE;
        unique case (state_q)
            ST_IDLE:     rsp_valid = 1'b0;
            ST_DONE:     rsp_exc   = EXC_NONE;
            ST_GP_FAULT: rsp_exc   = EXC_GP;
            ST_UD_FAULT: rsp_exc   = EXC_UD;
            ST_DB_TRAP:  rsp_exc   = EXC_DB;
            default:     rsp_valid = 1'b0;
        endcase
    end

    assign rsp_rdata = rdata_q;

endmodule

// File: rtl/dbgrf_sva.sv
module dbgrf_sva
    import dbgrf_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_idx,
    input logic [1:0]    req_cpl,
    input logic          alias_off,
    input logic          task_sw,
    input logic          bp_hit0,
    input logic          rsp_valid,
    input logic [1:0]    rsp_exc,
    input logic [31:0]   rsp_rdata,
    input logic [DW-1:0] stat_rd,
    input logic [DW-1:0] ctrl_rd
);
    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R4
    priv_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cpl != 2'd0) |=> (rsp_exc == EXC_GP));
    // R3
    alias_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cpl == 2'd0 && req_idx[2:1] == 2'b10 && alias_off)
        |=> (rsp_exc == EXC_UD));
    // R6
    gd_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc == EXC_DB) |-> (!ctrl_rd[GD_BIT] && stat_rd[GD_BIT]));
    // R7
    stat_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_rd & 32'hFFFF_1FF0) == 32'hFFFF_0FF0));
    // R8
    ctrl_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_rd & 32'h0000_DC00) == 32'h0000_0400));
    // R9
    local_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        task_sw |=> ((ctrl_rd & 32'h0000_0055) == 32'h0));
    // R10
    bp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bp_hit0 |=> stat_rd[0]);
    // R12
    exc_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc != EXC_NONE) |-> (rsp_rdata == 32'h0));
endmodule

bind dbgrf_top dbgrf_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_idx   (req_idx),
    .req_cpl   (req_cpl),
    .alias_off (alias_off),
    .task_sw   (task_sw),
    .bp_hit0   (bp_hit[0]),
    .rsp_valid (rsp_valid),
    .rsp_exc   (rsp_exc),
    .rsp_rdata (rsp_rdata),
    .stat_rd   (stat_rd),
    .ctrl_rd   (ctrl_rd)
);

// File: tb/sim_dbgrf_top.sv
`timescale 1ns/1ps
module sim_dbgrf_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_idx = '0;
    logic        req_wr = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_cpl = '0;
    logic        alias_off = 1'b0;
    logic        task_sw = 1'b0;
    logic [3:0]  bp_hit = '0;
    logic        step_hit = 1'b0;
    logic        trap_hit = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_exc;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    logic [1:0]  got_exc;
    logic [31:0] got_data;
    logic        got_valid;

    always #5 clk = ~clk;

    dbgrf_top u0 (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // drive one request at a falling edge, capture its response one cycle later
    task automatic access(input logic [2:0] idx, input logic wr,
                          input logic [31:0] d, input logic [1:0] cpl);
        @(negedge clk);
        req_valid = 1'b1; req_idx = idx; req_wr = wr; req_wdata = d; req_cpl = cpl;
        @(negedge clk);
        req_valid = 1'b0; req_wr = 1'b0;
        got_valid = rsp_valid; got_exc = rsp_exc; got_data = rsp_rdata;
    endtask

    task automatic read_expect(string tag, input logic [2:0] idx, input logic [31:0] exp);
        access(idx, 1'b0, 32'h0, 2'd0);
        check(tag, {30'h0, got_exc}, 32'h0);
        check(tag, got_data, exp);
    endtask

    task automatic t_reset();
        check("R1 idle no rsp", {31'h0, rsp_valid}, 32'h0);
        read_expect("R11 addr0", 3'd0, 32'h0);
        check("R1 rsp_valid", {31'h0, got_valid}, 32'h1);
        read_expect("R11 status", 3'd6, 32'hFFFF_0FF0);
        read_expect("R11 control", 3'd7, 32'h0000_0400);
    endtask

    task automatic t_addr();
        access(3'd1, 1'b1, 32'hDEAD_BEEF, 2'd0);
        check("R12 write data zero", got_data, 32'h0);
        access(3'd3, 1'b1, 32'h1357_9BDF, 2'd0);
        read_expect("R1 addr1", 3'd1, 32'hDEAD_BEEF);
        read_expect("R1 addr3", 3'd3, 32'h1357_9BDF);
        @(negedge clk);
        check("R1 no rsp after gap", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_alias_ctrl();
        alias_off = 1'b0;
        access(3'd5, 1'b1, 32'h0F0F_D8FF, 2'd0);
        read_expect("R2 R8 ctrl via 7", 3'd7, 32'h0F0F_04FF);
        read_expect("R2 ctrl via 5", 3'd5, 32'h0F0F_04FF);
        @(negedge clk); task_sw = 1'b1;
        @(negedge clk); task_sw = 1'b0;
        read_expect("R9 locals wiped", 3'd7, 32'h0F0F_04AA);
    endtask

    task automatic t_status();
        access(3'd4, 1'b1, 32'hFFFF_FFFF, 2'd0);
        read_expect("R2 R7 status ones", 3'd6, 32'hFFFF_EFFF);
        access(3'd6, 1'b1, 32'h0, 2'd0);
        read_expect("R7 status cleared", 3'd6, 32'hFFFF_0FF0);
        @(negedge clk); bp_hit = 4'b0101; step_hit = 1'b1;
        @(negedge clk); bp_hit = 4'b0; step_hit = 1'b0;
        repeat (3) @(negedge clk);
        read_expect("R10 sticky hits", 3'd6, 32'hFFFF_4FF5);
        @(negedge clk); trap_hit = 1'b1;
        @(negedge clk); trap_hit = 1'b0;
        read_expect("R10 trap bit", 3'd6, 32'hFFFF_CFF5);
    endtask

    task automatic t_faults();
        access(3'd1, 1'b1, 32'h0000_1234, 2'd3);
        check("R4 gp code", {30'h0, got_exc}, 32'h1);
        check("R12 gp data zero", got_data, 32'h0);
        read_expect("R4 addr1 unchanged", 3'd1, 32'hDEAD_BEEF);
        alias_off = 1'b1;
        access(3'd5, 1'b1, 32'h0000_0003, 2'd0);
        check("R3 ud code", {30'h0, got_exc}, 32'h2);
        read_expect("R3 ctrl unchanged", 3'd7, 32'h0F0F_04AA);
        access(3'd4, 1'b0, 32'h0, 2'd1);
        check("R5 gp over ud", {30'h0, got_exc}, 32'h1);
    endtask

    task automatic t_gd();
        alias_off = 1'b0;
        access(3'd7, 1'b1, 32'h0000_2000, 2'd0);
        alias_off = 1'b1;
        access(3'd4, 1'b0, 32'h0, 2'd2);
        check("R5 gp over db", {30'h0, got_exc}, 32'h1);
        access(3'd4, 1'b0, 32'h0, 2'd0);
        check("R5 ud over db", {30'h0, got_exc}, 32'h2);
        alias_off = 1'b0;
        access(3'd0, 1'b1, 32'hFFFF_FFFF, 2'd0);
        check("R6 db code", {30'h0, got_exc}, 32'h3);
        read_expect("R6 addr0 untouched", 3'd0, 32'h0);
        read_expect("R6 status bit13", 3'd6, 32'hFFFF_EFF5);
        read_expect("R6 gd disarmed", 3'd7, 32'h0000_0400);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_addr();
        t_alias_ctrl();
        t_status();
        t_faults();
        t_gd();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule